// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Aligner

This block sits behind the analog stages of a pipelined converter and turns the raw stage codes into one output word per sample. The stages resolve a sample one after another, so a given slot on the input bus carries codes from different samples: stage 0 holds the newest sample and the last stage holds the oldest. The block delays every stage code by a register skew, so that all codes of one sample line up. It then merges them with overlapped addition. Each corrected stage adds one bit fewer than its raw code width, and the final stage passes through unmodified.

The stage count, the raw code width and the final-stage width can be set freely. Two presets are built in. One is four stages of 4-4-4-3 bits giving a 12-bit word. The other is nine stages, eight of three levels followed by a 2-bit quantizer, giving a 10-bit word. One input beat is one slot of stage codes, and it moves under valid/ready flow control. The corrected word leaves through a one-entry valid/ready output register. The block applies back-pressure by dropping `in_ready` when that register is full and not being read. While `in_ready` is low, a held input beat is neither consumed nor shifted.

Top module: `pipe_adc_aligner`

## Requirements
- R1: The code in slot i of the input (stage i, counted from the first stage) is combined with codes of the same sample only: the word for sample n uses stage i's code from the (n+i)-th accepted beat.
- R2: The word equals C_last + Σ C_i·2^(K_i−1) over the corrected stages i = 0..S−2, where K_i = LAST_W + (S−2−i)·(CODE_W−1). The word is LAST_W + (S−1)·(CODE_W−1) bits wide.
- R3: The final stage is not corrected. Its value is the low LAST_W bits of slot S−1, and any higher bits in that slot have no effect on the word.
- R4: A corrected stage code above 2^CODE_W − 2 is treated as 2^CODE_W − 2, so the word never exceeds full scale.
- R5: After reset, `out_valid` stays low until S beats have been accepted, and it rises in the cycle after the S-th accepted beat.
- R6: A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being read in that cycle. Every accepted beat from the S-th onward yields exactly one word, in order, and no word appears without an accepted beat.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold their values.
- R8: A synchronous reset clears all delay and fill registers and the output register. After it, `out_valid` is low and `in_ready` is high.
- R9: The preset 4-4-4-3 (codes 0..14, last stage 0..7) gives 4095 at full scale. The nine-stage three-level preset (codes 0..2, last stage 0..3) gives 1023 at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_codes | input | N_ST*CODE_W | Stage codes; slot i occupies bits [i*CODE_W +: CODE_W] |
| out_valid | output | 1 | Corrected word present |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | OUT_W | Aligned, corrected output word |

## Verification
A skew register at the wrong depth mixes codes from neighbouring samples. That shows up at the ports in the very first word after fill, as a value off by a stage weight times a code difference. A bad weight or a missing clamp shows up in the full-scale and over-range corner words, which are sent right after fill. A fill chain of the wrong length moves the rising edge of `out_valid` by a cycle. A stall fault changes the held word in the cycle after `out_ready` drops.

// File: rtl/pipe_adc_pkg.sv
package pipe_adc_pkg;

  typedef enum int {
    PRESET_4443     = 0,
    PRESET_HALF_BIT = 1,
    PRESET_CUSTOM   = 2
  } preset_e;

  function automatic int stages_of(preset_e p, int custom);
    case (p)
      PRESET_4443:     return 4;
      PRESET_HALF_BIT: return 9;
      default:         return custom;
    endcase
  endfunction

  function automatic int code_w_of(preset_e p, int custom);
    case (p)
      PRESET_4443:     return 4;
      PRESET_HALF_BIT: return 2;
      default:         return custom;
    endcase
  endfunction

  function automatic int last_w_of(preset_e p, int custom);
    case (p)
      PRESET_4443:     return 3;
      PRESET_HALF_BIT: return 2;
      default:         return custom;
    endcase
  endfunction

  // width of the merged word: last stage plus one bit less per corrected stage
  function automatic int word_w(int s, int cw, int lw);
    return lw + (s - 1) * (cw - 1);
  endfunction

  // left shift applied to corrected stage i (0 = first stage)
  function automatic int stage_shift(int i, int s, int cw, int lw);
    return lw - 1 + (s - 2 - i) * (cw - 1);
  endfunction

endpackage

// File: rtl/pipe_adc_skew.sv
module pipe_adc_skew #(
  parameter int S  = 4,
  parameter int CW = 4,
  localparam int W = S * CW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] codes_in,
  output logic [W-1:0] codes_out
);

  for (genvar i = 0; i < S; i++) begin : g_lane
    localparam int D = S - 1 - i;
    if (D == 0) begin : g_pass
      assign codes_out[i*CW +: CW] = codes_in[i*CW +: CW];
    end else begin : g_dly
      logic [CW-1:0] dl [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < D; k++) dl[k] <= '0;
        end else if (adv) begin
          dl[0] <= codes_in[i*CW +: CW];
          for (int k = 1; k < D; k++) dl[k] <= dl[k-1];
        end
      end
      assign codes_out[i*CW +: CW] = dl[D-1];
    end
  end

endmodule

// File: rtl/pipe_adc_merge.sv
module pipe_adc_merge
  import pipe_adc_pkg::*;
#(
  parameter int S  = 4,
  parameter int CW = 4,
  parameter int LW = 3,
  localparam int OW   = word_w(S, CW, LW),
  localparam int MAXC = (1 << CW) - 2
) (
  input  logic [S*CW-1:0] aligned,
  output logic [OW-1:0]   word
);

  logic [OW-1:0] term [S];

  for (genvar i = 0; i < S; i++) begin : g_term
    if (i == S - 1) begin : g_last
      assign term[i] = OW'(aligned[i*CW +: LW]);
    end else begin : g_corr
      localparam int SH = stage_shift(i, S, CW, LW);
      logic [CW-1:0] raw;
      logic [CW-1:0] lim;
      assign raw     = aligned[i*CW +: CW];
      assign lim     = (raw > CW'(MAXC)) ? CW'(MAXC) : raw;
      assign term[i] = OW'(lim) << SH;
    end
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < S; k++) word = word + term[k];
  end

endmodule

// File: rtl/pipe_adc_aligner.sv
module pipe_adc_aligner
  import pipe_adc_pkg::*;
#(
  parameter preset_e PRESET      = PRESET_4443,
  parameter int      CUST_STAGES = 4,
  parameter int      CUST_CODE_W = 4,
  parameter int      CUST_LAST_W = 3,
  localparam int N_ST   = stages_of(PRESET, CUST_STAGES),
  localparam int CODE_W = code_w_of(PRESET, CUST_CODE_W),
  localparam int LAST_W = last_w_of(PRESET, CUST_LAST_W),
  localparam int OUT_W  = word_w(N_ST, CODE_W, LAST_W),
  localparam int IN_W   = N_ST * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_codes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_word
);

  localparam int FILL_W = N_ST - 1;

  logic              adv;
  logic              acc;
  logic [IN_W-1:0]   aligned;
  logic [OUT_W-1:0]  merged;
  logic [FILL_W-1:0] fill_q;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign acc      = in_valid && adv;

  pipe_adc_skew #(.S(N_ST), .CW(CODE_W)) u_skew (
    .clk      (clk),
    .rst      (rst),
    .adv      (acc),
    .codes_in (in_codes),
    .codes_out(aligned)
  );

  pipe_adc_merge #(.S(N_ST), .CW(CODE_W), .LW(LAST_W)) u_merge (
    .aligned(aligned),
    .word   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (acc) begin
      fill_q <= (fill_q << 1) | FILL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (adv) begin
      out_valid <= acc && fill_q[FILL_W-1];
      if (acc) out_word <= merged;
    end
  end

endmodule

// File: rtl/pipe_adc_aligner_chk.sv
module pipe_adc_aligner_chk #(
  parameter int S  = 4,
  parameter int OW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_word
);

  int unsigned fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= 0;
    else if (in_valid && in_ready && fill_cnt < S) fill_cnt <= fill_cnt + 1;
  end

  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fill_cnt >= S));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_word_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

bind pipe_adc_aligner pipe_adc_aligner_chk #(.S(N_ST), .OW(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_word (out_word)
);

// File: tb/test_pipe_adc_aligner.sv
`timescale 1ns/1ps
module test_pipe_adc_aligner;

  localparam int NS = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        sel = 1'b0;
  logic        drv_valid = 1'b0;
  logic [17:0] drv_codes = '0;
  logic        rdy = 1'b1;

  logic        a_in_ready, a_out_valid;
  logic [11:0] a_word;
  logic        b_in_ready, b_out_valid;
  logic [9:0]  b_word;

  pipe_adc_aligner #(.PRESET(pipe_adc_pkg::PRESET_4443)) i_pipe_adc_aligner (
    .clk(clk), .rst(rst),
    .in_valid(drv_valid && !sel), .in_ready(a_in_ready), .in_codes(drv_codes[15:0]),
    .out_valid(a_out_valid), .out_ready(rdy || sel), .out_word(a_word)
  );

  pipe_adc_aligner #(.PRESET(pipe_adc_pkg::PRESET_HALF_BIT)) i_pipe_adc_aligner_half (
    .clk(clk), .rst(rst),
    .in_valid(drv_valid && sel), .in_ready(b_in_ready), .in_codes(drv_codes),
    .out_valid(b_out_valid), .out_ready(rdy || !sel), .out_word(b_word)
  );

  logic        cur_ir, cur_ov;
  logic [11:0] cur_word;
  assign cur_ir   = sel ? b_in_ready : a_in_ready;
  assign cur_ov   = sel ? b_out_valid : a_out_valid;
  assign cur_word = sel ? {2'b00, b_word} : a_word;

  int checks = 0;
  int fails  = 0;
  int samp [NS][9];

  function automatic int st_of(bit c);  return c ? 9 : 4; endfunction
  function automatic int cw_of(bit c);  return c ? 2 : 4; endfunction
  function automatic int lw_of(bit c);  return c ? 2 : 3; endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 R3 R4: expected merged word from the requirement formula
  function automatic longint exp_word(bit c, int s);
    int S = st_of(c), cw = cw_of(c), lw = lw_of(c);
    longint r = 0;
    for (int i = 0; i < S - 1; i++) begin
      int v = samp[s][i];
      if (v > (1 << cw) - 2) v = (1 << cw) - 2;
      r += longint'(v) << (lw - 1 + (S - 2 - i) * (cw - 1));
    end
    r += samp[s][S-1] & ((1 << lw) - 1);
    return r;
  endfunction

  // R1: beat b carries stage i of sample b-i
  function automatic logic [17:0] beat(bit c, int b);
    int S = st_of(c), cw = cw_of(c);
    logic [17:0] r = '0;
    for (int i = 0; i < S; i++) begin
      int s = b - i;
      int v = (s >= 0 && s < NS) ? samp[s][i] : int'($urandom % (1 << cw));
      r |= 18'(v) << (i * cw);
    end
    return r;
  endfunction

  task automatic run_cfg(bit c);
    int S = st_of(c), cw = cw_of(c), lw = lw_of(c);
    int bi = 0, wi = 0, acc_cnt = 0, guard = 0;
    bit first_seen = 0, hold_pending = 0;
    logic [11:0] held_word = '0;

    @(negedge clk);
    sel = c; rst = 1'b0; drv_valid = 1'b1; rdy = 1'b0;
    repeat (S + 2) begin
      drv_codes = 18'($urandom);
      @(negedge clk);
    end
    rst = 1'b1; drv_valid = 1'b0; rdy = 1'b1;
    @(negedge clk); @(negedge clk);
    #1;
    chk("R8 out_valid cleared by reset", cur_ov, 0);
    chk("R8 in_ready after reset", cur_ir, 1);

    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < S; i++) begin
        int mx = (i == S - 1) ? (1 << lw) - 1 : (1 << cw) - 2;
        case (s)
          0:       samp[s][i] = mx;
          1:       samp[s][i] = 0;
          2:       samp[s][i] = (1 << cw) - 1;
          3:       samp[s][i] = (i % 2) ? mx : 0;
          default: samp[s][i] = int'($urandom % (1 << cw));
        endcase
      end
    end

    @(negedge clk);
    rst = 1'b0;
    while (wi < NS && guard < 20000) begin
      @(negedge clk);
      guard++;
      drv_valid = (bi < NS + S - 1) && ($urandom % 4 != 0);
      drv_codes = beat(c, bi);
      rdy = ($urandom % 3 != 0);
      #1;
      if (hold_pending) begin
        chk("R7 valid held under stall", cur_ov, 1);
        chk("R7 word held under stall", cur_word, held_word);
        hold_pending = 0;
      end
      if (cur_ov && !first_seen) begin
        first_seen = 1;
        chk("R5 beats accepted before first word", acc_cnt, S);
      end
      if (cur_ov && rdy) begin
        chk("R1 R2 R3 R4 aligned word", cur_word, exp_word(c, wi));
        if (wi == 0) chk("R9 full-scale word", cur_word, c ? 1023 : 4095);
        wi++;
      end else if (cur_ov) begin
        hold_pending = 1;
        held_word = cur_word;
      end
      if (drv_valid && cur_ir) begin
        bi++;
        acc_cnt++;
      end
    end
    chk("R6 words delivered", wi, NS);

    @(negedge clk);
    drv_valid = 1'b0; rdy = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R6 no word without accepted beat", cur_ov, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset state out_valid", a_out_valid, 0);
    chk("R8 reset state in_ready", a_in_ready, 1);
    void'($urandom(32'd4242));
    run_cfg(1'b0);
    run_cfg(1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule